// File: doc/BRIEF.md
# Power Zone Phase Shedding Controller

This block decides how many phases of a multiphase buck regulator switch at any moment. It reduces that decision to a power zone code from 0 to 4 and a per-phase enable mask. Zone 0 runs every configured phase. Higher zones run fewer phases. Zone 4 is a single phase in discontinuous operation.

The zone comes from a three-level operating mode:

- **High mode** pins the zone at 0.
- **Low mode** pins it to one of two register settings. The setting used depends on whether the enable followed a cold supply start or was a warm re-enable.
- **Mid mode** compares a digitized total-current sample against a ladder of four thresholds. The comparison runs once per fixed sampling period.

Until the regulated output reports that it is in regulation, the block keeps the zone it chose when enable rose. Mode changes during that time have no effect.

The surrounding logic supplies the current sample, the threshold and zone registers, and a regulation flag. The block's outputs go to the per-phase modulators. A diode-emulation flag tells phase 1 to use its three-level drive with zero-current detection.

Top module: `zone_shed_ctrl`

## Requirements
- R1: While `en` is low, on the next clock `zone` is 0, `phase_en` is all zeros and `diode_emu` is 0.
- R2: With `mode_in` = 2'b10 or 2'b11 (high) in effect, `zone` is 0 and `phase_en` enables every configured phase, whatever `cur_sample` is.
- R3: With `mode_in` = 2'b01 (mid) in effect and `in_reg` high, the zone is chosen from a threshold ladder. The ladder is evaluated once every `SAMPLE_CYCLES` clocks and the result is held between evaluations; zone 0 is used until the first evaluation after mid mode becomes active. The ladder checks thresholds in priority order, and a sample equal to a threshold does not count as below it:
  - `cur_sample` below TH1 selects zone 4;
  - otherwise, below TH2 selects zone 3;
  - otherwise, below TH3 selects zone 2;
  - otherwise, below TH4 selects zone 1;
  - otherwise zone 0.
- R4: A threshold whose value is all ones (0xFF) is skipped in the ladder. TH1 sits in `thr_vec[7:0]`, TH2 in `[15:8]`, TH3 in `[23:16]` and TH4 in `[31:24]`.
- R5: `mode_in` is captured on the rising edge of `en`. While `in_reg` is low the captured mode is used and later changes on `mode_in` are ignored. Mid mode does no shedding before regulation: its zone is 0.
- R6: In low mode (`mode_in` = 2'b00) the zone comes from a register:
  - `lowz_cold` when `cold_boot` was high at the rising edge of `en`;
  - `lowz_warm` otherwise.
  A later change of `cold_boot` has no effect. Values above 4 act as 4.
- R7: The mask enables the lowest-numbered phases only, and phase 1 (`phase_en[0]`) is always on while `en` is high. The phase count depends on the zone, for `NUM_PHASES` = 8:
  - zone 0 gives 8;
  - zone 1 gives 4;
  - zone 2 gives 2;
  - zones 3 and 4 give 1.
  The count is capped at `cfg_phases`, and a `cfg_phases` of 0 counts as 1.
- R8: `diode_emu` is 1 exactly when low mode is in effect, the zone is 4 and `zcd_en` is high.
- R9: `zone`, `phase_en` and `diode_emu` are registered; they follow a change on `en`, `mode_in`, `in_reg`, the registers or `cfg_phases` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Regulator enable |
| mode_in | input | 2 | Operating mode: 00 low, 01 mid, 10/11 high |
| in_reg | input | 1 | Output has reached its nominal regulated voltage |
| cold_boot | input | 1 | Enable follows a supply power-on (1) or is a re-enable (0) |
| cur_sample | input | 8 | Digitized total output current |
| thr_vec | input | 32 | Four shedding thresholds, TH1 in the low byte |
| lowz_cold | input | 3 | Low-mode zone after a cold start |
| lowz_warm | input | 3 | Low-mode zone after a re-enable |
| cfg_phases | input | 4 | Number of populated phases |
| zcd_en | input | 1 | Zero-current detection enable |
| zone | output | 3 | Active power zone |
| phase_en | output | 8 | Per-phase enable mask, bit 0 is phase 1 |
| diode_emu | output | 1 | Phase 1 runs in diode emulation |

## Verification
The assertions watch, on every clock, that:
- a disabled block drives everything off;
- high mode yields zone 0;
- phase 1 stays on under enable and the mask stays a contiguous run from bit 0;
- diode emulation never appears outside zone 4;
- the shedding result never moves between sampling ticks.

The ordering of the threshold ladder, the skipping of all-ones thresholds and the equality rule can only be shown by the bench scenarios. The same holds for the capture of mode and boot kind at enable, the clamping and capping of phase counts, and the hold of the zone before regulation.

// File: rtl/zsc_pkg.sv
// Shared types for the power zone shedding controller.
// Assumes the mode input is already resolved to two digital bits.
package zsc_pkg;
    typedef enum logic [1:0] {
        MODE_LOW  = 2'b00,
        MODE_MID  = 2'b01,
        MODE_HIGH = 2'b10,
        MODE_HALT = 2'b11   // second encoding of high mode
    } mode_e;
endpackage

// File: rtl/zsc_ladder.sv
// Threshold ladder: maps one current sample onto a zone code.
// Assumes threshold index 0 is the lowest current step; an all-ones
// threshold is disabled. Pure combinational logic.
module zsc_ladder #(
    parameter int NUM_TH = 4,
    parameter int CUR_W  = 8,
    parameter int ZONE_W = 3
) (
    input  logic [CUR_W-1:0]        cur,
    input  logic [NUM_TH*CUR_W-1:0] thr,
    output logic [ZONE_W-1:0]       zone
);
    localparam logic [CUR_W-1:0] TH_OFF = '1;

    logic [NUM_TH-1:0] below;

    // Per-threshold compare, skipped when disabled.
    for (genvar i = 0; i < NUM_TH; i++) begin : g_cmp
        assign below[i] = (thr[i*CUR_W +: CUR_W] != TH_OFF) &&
                          (cur < thr[i*CUR_W +: CUR_W]);
    end

    // Priority pick: the lowest threshold that is exceeded from below wins.
    always_comb begin
        zone = '0;
        for (int i = NUM_TH - 1; i >= 0; i--) begin
            if (below[i]) zone = ZONE_W'(NUM_TH - i);
        end
    end
endmodule

// File: rtl/zsc_sampler.sv
// Periodic shedding sampler: latches the ladder result once per period.
// Assumes active is high only in regulated mid mode; while inactive the
// timer restarts and the held zone returns to 0.
module zsc_sampler #(
    parameter int SAMPLE_CYCLES = 1000,
    parameter int ZONE_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [ZONE_W-1:0] ladder_zone,
    output logic [ZONE_W-1:0] shed_zone
);
    localparam int TW = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(SAMPLE_CYCLES - 1);

    logic [TW-1:0] cnt;
    logic          tick;

    assign tick = active && (cnt == LAST);

    // Period timer and held shedding decision.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt       <= '0;
            shed_zone <= '0;
        end else if (tick) begin
            cnt       <= '0;
            shed_zone <= ladder_zone;
        end else begin
            cnt       <= cnt + 1'b1;
        end
    end

    // R3: decision only moves on a sampling tick
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(shed_zone));
endmodule

// File: rtl/zsc_mask.sv
// Zone to phase-enable mask. Zone 0 keeps all phases, each further zone
// halves the count, the last two zones keep one; capped by the populated
// phase count. Assumes cfg of 0 means one phase. Combinational.
module zsc_mask #(
    parameter int NUM_PHASES = 8,
    parameter int NUM_TH     = 4,
    parameter int ZONE_W     = 3,
    parameter int CNT_W      = 4
) (
    input  logic [ZONE_W-1:0]     zone,
    input  logic [CNT_W-1:0]      cfg_phases,
    output logic [NUM_PHASES-1:0] mask
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_PHASES);

    logic [CNT_W-1:0] base, lim, cnt;

    // Phase count for the zone, then limited to what is populated.
    always_comb begin
        if (zone >= ZONE_W'(NUM_TH - 1)) base = ONE;
        else                             base = CNT_W'(NUM_PHASES >> zone);
        if (base == '0) base = ONE;
        if (cfg_phases == '0)       lim = ONE;
        else if (cfg_phases > FULL) lim = FULL;
        else                        lim = cfg_phases;
        cnt = (base < lim) ? base : lim;
    end

    // Thermometer mask: lowest-numbered phases stay active.
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_bit
        assign mask[p] = (CNT_W'(p) < cnt);
    end
endmodule

// File: rtl/zone_shed_ctrl.sv
// Power zone and phase enable selection for a multiphase regulator.
// Captures mode and boot kind at enable, holds the boot zone until the
// output is in regulation, then follows high/mid/low mode. Outputs are
// registered. Assumes all inputs are synchronous to clk.
module zone_shed_ctrl
    import zsc_pkg::*;
#(
    parameter int NUM_PHASES    = 8,
    parameter int NUM_TH        = 4,
    parameter int CUR_W         = 8,
    parameter int SAMPLE_CYCLES = 1000,
    localparam int ZONE_W       = $clog2(NUM_TH + 1),
    localparam int CNT_W        = $clog2(NUM_PHASES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [1:0]              mode_in,
    input  logic                    in_reg,
    input  logic                    cold_boot,
    input  logic [CUR_W-1:0]        cur_sample,
    input  logic [NUM_TH*CUR_W-1:0] thr_vec,
    input  logic [ZONE_W-1:0]       lowz_cold,
    input  logic [ZONE_W-1:0]       lowz_warm,
    input  logic [CNT_W-1:0]        cfg_phases,
    input  logic                    zcd_en,
    output logic [ZONE_W-1:0]       zone,
    output logic [NUM_PHASES-1:0]   phase_en,
    output logic                    diode_emu
);
    localparam logic [ZONE_W-1:0] ZMAX = ZONE_W'(NUM_TH);

    logic                  en_q, rise;
    mode_e                 mode_boot_q, boot_mode, eff_mode;
    logic                  cold_q, boot_cold;
    logic [ZONE_W-1:0]     low_raw, low_zone, ladder_zone, shed_zone, next_zone;
    logic [NUM_PHASES-1:0] next_mask;
    logic                  shed_active, next_diode;

    assign rise = en && !en_q;

    // Capture mode and boot kind on the rising edge of enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            mode_boot_q <= MODE_HIGH;
            cold_q      <= 1'b0;
        end else begin
            en_q <= en;
            if (rise) begin
                mode_boot_q <= mode_e'(mode_in);
                cold_q      <= cold_boot;
            end
        end
    end

    // Effective mode: captured value until regulation, live afterwards.
    always_comb begin
        boot_mode = rise ? mode_e'(mode_in) : mode_boot_q;
        boot_cold = rise ? cold_boot : cold_q;
        eff_mode  = in_reg ? mode_e'(mode_in) : boot_mode;
    end

    // Low-mode zone from the boot-selected register, clamped to the top zone.
    always_comb begin
        low_raw  = boot_cold ? lowz_cold : lowz_warm;
        low_zone = (low_raw > ZMAX) ? ZMAX : low_raw;
    end

    assign shed_active = en && in_reg && (eff_mode == MODE_MID);

    zsc_ladder #(.NUM_TH(NUM_TH), .CUR_W(CUR_W), .ZONE_W(ZONE_W)) u_ladder (
        .cur  (cur_sample),
        .thr  (thr_vec),
        .zone (ladder_zone)
    );

    zsc_sampler #(.SAMPLE_CYCLES(SAMPLE_CYCLES), .ZONE_W(ZONE_W)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (shed_active),
        .ladder_zone (ladder_zone),
        .shed_zone   (shed_zone)
    );

    // Zone selection by effective mode.
    always_comb begin
        if (!en)                        next_zone = '0;
        else if (eff_mode == MODE_LOW)  next_zone = low_zone;
        else if (eff_mode == MODE_MID)  next_zone = in_reg ? shed_zone : '0;
        else                            next_zone = '0;
    end

    zsc_mask #(.NUM_PHASES(NUM_PHASES), .NUM_TH(NUM_TH), .ZONE_W(ZONE_W),
               .CNT_W(CNT_W)) u_mask (
        .zone       (next_zone),
        .cfg_phases (cfg_phases),
        .mask       (next_mask)
    );

    assign next_diode = en && (eff_mode == MODE_LOW) && (next_zone == ZMAX) && zcd_en;

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone      <= '0;
            phase_en  <= '0;
            diode_emu <= 1'b0;
        end else begin
            zone      <= next_zone;
            phase_en  <= en ? next_mask : '0;
            diode_emu <= next_diode;
        end
    end

    // R1: disabled block drives everything off
    a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (zone == '0 && phase_en == '0 && !diode_emu));
    // R2: high mode in regulation gives zone 0
    a_r2_high_zone0: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_reg && mode_in[1]) |=> (zone == '0));
    // R7: phase 1 never shed while enabled
    a_r7_phase1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> phase_en[0]);
    // R7: mask is a contiguous run from bit 0
    a_r7_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_en & (phase_en + 1'b1)) == '0));
    // R8: diode emulation only in the top zone on a single phase
    a_r8_diode_zone: assert property (@(posedge clk) disable iff (!rst_n)
        diode_emu |-> (zone == ZMAX && $countones(phase_en) == 1));
endmodule

// File: tb/tb_zone_shed_ctrl.sv
module tb_zone_shed_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        en = 0;
    logic [1:0]  mode_in = 2'b10;
    logic        in_reg = 0;
    logic        cold_boot = 0;
    logic [7:0]  cur_sample = 0;
    logic [31:0] thr_vec = {8'd80, 8'd60, 8'd40, 8'd20};
    logic [2:0]  lowz_cold = 0;
    logic [2:0]  lowz_warm = 0;
    logic [3:0]  cfg_phases = 8;
    logic        zcd_en = 1;
    logic [2:0]  zone;
    logic [7:0]  phase_en;
    logic        diode_emu;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] z;
        logic [7:0] m;
        logic       d;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    zone_shed_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_in(mode_in), .in_reg(in_reg),
        .cold_boot(cold_boot), .cur_sample(cur_sample), .thr_vec(thr_vec),
        .lowz_cold(lowz_cold), .lowz_warm(lowz_warm), .cfg_phases(cfg_phases),
        .zcd_en(zcd_en), .zone(zone), .phase_en(phase_en), .diode_emu(diode_emu)
    );

    // Driver side: wait n clocks, then queue the expected outputs.
    task automatic expect_after(input int n, input logic [2:0] z,
                                input logic [7:0] m, input logic d, input string tag);
        exp_t e;
        repeat (n) @(posedge clk);
        #2;
        e.z = z; e.m = m; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare queued items against the outputs at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (zone !== e.z || phase_en !== e.m || diode_emu !== e.d) begin
                    bad++;
                    $display("FAIL %s: actual zone=%0d mask=%h diode=%b expected zone=%0d mask=%h diode=%b",
                             e.tag, zone, phase_en, diode_emu, e.z, e.m, e.d);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam int WAIT_S = 1100;

    initial begin
        repeat (3) @(posedge clk);
        expect_after(0, 3'd0, 8'h00, 1'b0, "R1 reset state");
        @(negedge clk); rst_n = 1;
        expect_after(2, 3'd0, 8'h00, 1'b0, "R1 disabled after reset");

        // High mode before and after regulation.
        @(negedge clk); en = 1; mode_in = 2'b10; cur_sample = 8'd5;
        expect_after(2, 3'd0, 8'hFF, 1'b0, "R2 high before regulation");
        @(negedge clk); in_reg = 1;
        expect_after(2, 3'd0, 8'hFF, 1'b0, "R2 high regulated low current");
        @(negedge clk); mode_in = 2'b11;
        expect_after(2, 3'd0, 8'hFF, 1'b0, "R2 alternate high code");

        // Mid mode threshold ladder.
        @(negedge clk); mode_in = 2'b01; cur_sample = 8'd10;
        expect_after(5, 3'd0, 8'hFF, 1'b0, "R3 zone 0 before first sample");
        expect_after(WAIT_S, 3'd4, 8'h01, 1'b0, "R3 below TH1 zone 4");
        @(negedge clk); cur_sample = 8'd90;
        expect_after(WAIT_S, 3'd0, 8'hFF, 1'b0, "R3 above TH4 zone 0");
        @(negedge clk); cur_sample = 8'd70;
        expect_after(WAIT_S, 3'd1, 8'h0F, 1'b0, "R3 between TH3 and TH4 zone 1, R7 four phases");
        @(negedge clk); cur_sample = 8'd50;
        expect_after(WAIT_S, 3'd2, 8'h03, 1'b0, "R3 zone 2, R7 two phases");
        @(negedge clk); cur_sample = 8'd30;
        expect_after(WAIT_S, 3'd3, 8'h01, 1'b0, "R3 zone 3");
        @(negedge clk); cur_sample = 8'd60;
        expect_after(WAIT_S, 3'd1, 8'h0F, 1'b0, "R3 equal to TH3 is not below");

        // Disabled thresholds.
        @(negedge clk); cur_sample = 8'd10; thr_vec[7:0] = 8'hFF;
        expect_after(WAIT_S, 3'd3, 8'h01, 1'b0, "R4 TH1 disabled");
        @(negedge clk); thr_vec[15:8] = 8'hFF;
        expect_after(WAIT_S, 3'd2, 8'h03, 1'b0, "R4 TH1 and TH2 disabled");
        @(negedge clk); thr_vec = {8'd80, 8'd60, 8'd40, 8'd20};

        // Phase count cap.
        @(negedge clk); cfg_phases = 4'd3; cur_sample = 8'd70;
        expect_after(WAIT_S, 3'd1, 8'h07, 1'b0, "R7 zone 1 capped at three phases");
        @(negedge clk); mode_in = 2'b10;
        expect_after(2, 3'd0, 8'h07, 1'b0, "R7 zone 0 capped at three phases");
        @(negedge clk); cfg_phases = 4'd0;
        expect_after(1, 3'd0, 8'h01, 1'b0, "R9 one-cycle update, R7 zero config is one phase");
        @(negedge clk); cfg_phases = 4'd8;

        // Low mode, cold boot, mode changes ignored before regulation.
        @(negedge clk); en = 0;
        expect_after(2, 3'd0, 8'h00, 1'b0, "R1 disable mid-run");
        @(negedge clk); in_reg = 0; mode_in = 2'b00; cold_boot = 1;
        lowz_cold = 3'd2; lowz_warm = 3'd4;
        @(negedge clk); en = 1;
        expect_after(2, 3'd2, 8'h03, 1'b0, "R6 cold boot register");
        @(negedge clk); mode_in = 2'b10; cold_boot = 0;
        expect_after(3, 3'd2, 8'h03, 1'b0, "R5 mode change ignored before regulation");
        @(negedge clk); in_reg = 1;
        expect_after(2, 3'd0, 8'hFF, 1'b0, "R5 live mode after regulation");

        // Low mode, warm boot, diode emulation.
        @(negedge clk); en = 0; in_reg = 0; mode_in = 2'b00; cold_boot = 0;
        @(negedge clk); en = 1;
        expect_after(2, 3'd4, 8'h01, 1'b1, "R6 warm register, R8 diode on");
        @(negedge clk); in_reg = 1; cold_boot = 1;
        expect_after(2, 3'd4, 8'h01, 1'b1, "R6 cold flag change ignored after enable");
        @(negedge clk); zcd_en = 0;
        expect_after(2, 3'd4, 8'h01, 1'b0, "R8 zero-current detect off");
        @(negedge clk); zcd_en = 1; lowz_warm = 3'd7;
        expect_after(2, 3'd4, 8'h01, 1'b1, "R6 register value above 4 clamps");
        @(negedge clk); lowz_warm = 3'd1;
        expect_after(2, 3'd1, 8'h0F, 1'b0, "R6 warm zone 1, R8 diode off outside zone 4");

        // Mid mode captured at enable: no shedding before regulation.
        @(negedge clk); en = 0; in_reg = 0; mode_in = 2'b01; cur_sample = 8'd10;
        @(negedge clk); en = 1;
        expect_after(WAIT_S, 3'd0, 8'hFF, 1'b0, "R5 no shedding before regulation");
        @(negedge clk); in_reg = 1;
        expect_after(WAIT_S, 3'd4, 8'h01, 1'b0, "R3 shedding starts once regulated");

        repeat (3) @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule